// File: doc/BRIEF.md
# Dual-phase circular-buffer pitch shifter

This block changes the pitch of a stream of signed audio samples in the time domain. Every accepted input sample is stored in two circular buffers. The two buffers are written half a buffer length apart. Both buffers are then read at one shared fractional read pointer. The read pointer moves forward by a ratio `delta` once per sample. A `delta` below one reads some slots more than once, which lowers the pitch. A `delta` above one skips slots, which raises the pitch. The output is the average of the two reads. Because the two buffers are written half a length apart, they never wrap onto stale data at the same point, and the averaging softens the clicks that a single buffer would produce.

The ratio comes from one of two sources. In manual mode it is taken from an input word and held inside the legal range. In modulation mode it is taken from an internal triangle-wave table. The table index advances after a programmable number of samples, so the pitch sweeps up and down periodically. Samples arrive far more slowly than the clock, so the interface is a plain data/valid pair on each side.

Top module: `pshift_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no input, `valid_o` is 0 and `data_o` is 0.
- R2: A sample is accepted when `valid_i` is high while the block is idle. Its result appears on `data_o` with `valid_o` high for exactly one cycle, four rising edges after the accepting edge. `valid_i` pulses that arrive while a sample is in flight are ignored and write nothing.
- R3: Buffer A stores each accepted sample at write index `w`. Buffer B stores it at `(w + 512) mod 1024`. `w` starts at 0 and increments by one, modulo 1024, per accepted sample.
- R4: The read pointer is unsigned fixed point with 10 integer bits and 16 fractional bits, and it starts at 0. Both buffers are read at its integer part (bits 25:16). The read happens after the write of the same sample, so a slot being written returns the new sample.
- R5: `data_o` equals floor((A + B) / 2). A and B are the two reads, taken as signed 32-bit values and summed in 33 bits without overflow.
- R6: After each sample the read pointer increases by the current `delta`, modulo 2^26, so its integer part wraps modulo 1024.
- R7: When `mod_en_i` is 0, `delta` is `delta_i` held to the range 0x08000 (0.5) to 0x20000 (2.0).
- R8: When `mod_en_i` is 1, `delta` is table entry `k` (k from 0 to 511). The entry is 0x8000 + 256*k for k < 256, and 0x8000 + 256*(511 - k) otherwise. This is one triangle period from 0.5 up to just under 1.5.
- R9: In modulation mode the table index advances by one (mod 512) after every `max(hold_i,1)` samples. While `mod_en_i` is 0, the index and the sample counter are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | 32 | Signed input sample |
| delta_i | input | 26 | Manual read increment, unsigned Q10.16 |
| mod_en_i | input | 1 | 1 selects the triangle-table increment |
| hold_i | input | 16 | Samples per table entry in modulation mode |
| valid_o | output | 1 | Output sample strobe, one cycle |
| data_o | output | 32 | Signed averaged output sample |

## Verification
Two things can happen on the same sample: the read slot can coincide with the slot being written, and in modulation mode the table index can step. With `delta` at 1.0 the read pointer sits exactly on buffer A's write slot, so every output must contain the fresh sample. With `hold_i` at 0 the index steps on every sample, including across the wrap from 511 to 0. A bench reference model, built from the requirements, predicts every output word, and each prediction is compared with the captured output. A double `valid_i` pulse checks that the second pulse is ignored: a pulse that was wrongly written would shift the buffer contents and make later outputs differ from the model.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DONE
  } ps_state_e;

  // triangle entry: half-scale plus a linear ramp up over the first half, down over the second
  function automatic logic [31:0] tri_value(input int unsigned idx,
                                            input int unsigned rom_aw,
                                            input int unsigned frac_w);
    int unsigned half;
    int unsigned pos;
    half = 1 << (rom_aw - 1);
    pos  = (idx < half) ? idx : (2 * half - 1 - idx);
    return 32'((1 << (frac_w - 1)) + (pos << (frac_w - (rom_aw - 1))));
  endfunction

endpackage

// File: rtl/pshift_ring.sv
module pshift_ring #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/pshift_delta_gen.sv
module pshift_delta_gen
  import pshift_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned ROM_AW = 9,
  parameter int unsigned HOLD_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic                     mod_en_i,
  input  logic [ADDR_W+FRAC_W-1:0] delta_man_i,
  input  logic [HOLD_W-1:0]        hold_i,
  output logic [ADDR_W+FRAC_W-1:0] delta_o
);
  localparam int unsigned PTR_W = ADDR_W + FRAC_W;
  localparam int unsigned ROM_N = 1 << ROM_AW;
  localparam logic [PTR_W-1:0] ONE  = PTR_W'(1) << FRAC_W;
  localparam logic [PTR_W-1:0] DMIN = ONE >> 1;
  localparam logic [PTR_W-1:0] DMAX = ONE << 1;

  logic [PTR_W-1:0]  rom_tab [ROM_N];
  logic [ROM_AW-1:0] idx_q;
  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W-1:0] hold_eff;
  logic [PTR_W-1:0]  man_clamped;
  logic              last_use;

  for (genvar g = 0; g < ROM_N; g++) begin : g_rom
    assign rom_tab[g] = PTR_W'(tri_value(g, ROM_AW, FRAC_W));
  end

  assign hold_eff    = (hold_i == '0) ? HOLD_W'(1) : hold_i;
  assign last_use    = ({1'b0, cnt_q} + 1'b1) >= {1'b0, hold_eff};
  assign man_clamped = (delta_man_i < DMIN) ? DMIN :
                       (delta_man_i > DMAX) ? DMAX : delta_man_i;
  assign delta_o     = mod_en_i ? rom_tab[idx_q] : man_clamped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (!mod_en_i) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (step_i) begin
      if (last_use) begin
        cnt_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_rom_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_en_i |-> (delta_o >= DMIN && delta_o < ONE + DMIN));

  assert_idx_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_i |=> (idx_q == '0 && cnt_q == '0));

  assert_idx_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_en_i && step_i && hold_i <= 16'd1) |=> (idx_q == $past(idx_q) + 1'b1 || !$past(mod_en_i)));

endmodule

// File: rtl/pshift_top.sv
module pshift_top
  import pshift_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned ROM_AW = 9,
  parameter int unsigned HOLD_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic [ADDR_W+FRAC_W-1:0] delta_i,
  input  logic                     mod_en_i,
  input  logic [HOLD_W-1:0]        hold_i,
  output logic                     valid_o,
  output logic [DATA_W-1:0]        data_o
);
  localparam int unsigned PTR_W = ADDR_W + FRAC_W;
  localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [PTR_W-1:0]  DMIN = (PTR_W'(1) << FRAC_W) >> 1;
  localparam logic [PTR_W-1:0]  DMAX = PTR_W'(1) << (FRAC_W + 1);

  ps_state_e                state_q;
  logic [DATA_W-1:0]        samp_q;
  logic [ADDR_W-1:0]        wr_idx_q;
  logic [PTR_W-1:0]         rd_ptr_q;
  logic [PTR_W-1:0]         delta;
  logic [ADDR_W-1:0]        rd_idx;
  logic [DATA_W-1:0]        rd_data [2];
  logic signed [DATA_W:0]   sum;
  logic                     step;

  assign rd_idx = rd_ptr_q[PTR_W-1 -: ADDR_W];
  assign step   = (state_q == ST_DONE);

  for (genvar p = 0; p < 2; p++) begin : g_phase
    localparam logic [ADDR_W-1:0] OFS = (p == 0) ? '0 : HALF;
    pshift_ring #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ring (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (state_q == ST_WRITE),
      .waddr_i (wr_idx_q + OFS),
      .wdata_i (samp_q),
      .re_i    (state_q == ST_READ),
      .raddr_i (rd_idx),
      .rdata_o (rd_data[p])
    );
  end

  pshift_delta_gen #(
    .ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .ROM_AW(ROM_AW), .HOLD_W(HOLD_W)
  ) u_delta (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .mod_en_i    (mod_en_i),
    .delta_man_i (delta_i),
    .hold_i      (hold_i),
    .delta_o     (delta)
  );

  assign sum = $signed({rd_data[0][DATA_W-1], rd_data[0]})
             + $signed({rd_data[1][DATA_W-1], rd_data[1]});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      samp_q   <= '0;
      wr_idx_q <= '0;
      rd_ptr_q <= '0;
      valid_o  <= 1'b0;
      data_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (valid_i) begin
          samp_q  <= data_i;
          state_q <= ST_WRITE;
        end
        ST_WRITE: state_q <= ST_READ;
        ST_READ:  state_q <= ST_DONE;
        ST_DONE: begin
          data_o   <= sum[DATA_W:1];
          valid_o  <= 1'b1;
          wr_idx_q <= wr_idx_q + 1'b1;
          rd_ptr_q <= rd_ptr_q + delta;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_valid_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && valid_i) |-> ##4 valid_o);

  assert_wr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> wr_idx_q == $past(wr_idx_q) + 1'b1);

  assert_rd_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> rd_ptr_q == PTR_W'($past(rd_ptr_q) + $past(delta)));

  assert_delta_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_i |-> (delta >= DMIN && delta <= DMAX));

endmodule

// File: tb/pshift_top_bench.sv
module pshift_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [25:0] delta_i = 26'h10000;
  logic        mod_en_i = 1'b0;
  logic [15:0] hold_i = '0;
  logic        valid_o;
  logic [31:0] data_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] ref_a [1024];
  logic [31:0] ref_b [1024];
  int          wr_m = 0;
  logic [25:0] rd_m = '0;
  int          idx_m = 0;
  int          cnt_m = 0;
  int          n_samp = 0;

  always #5ns clk_i = ~clk_i;

  pshift_top u_pshift_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .delta_i(delta_i), .mod_en_i(mod_en_i), .hold_i(hold_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [25:0] tri_ref(input int k);
    int pos;
    pos = (k < 256) ? k : 511 - k;
    return 26'(32'h8000 + 256 * pos);
  endfunction

  function automatic logic [25:0] delta_ref();
    if (mod_en_i) return tri_ref(idx_m);
    if (delta_i < 26'h08000) return 26'h08000;
    if (delta_i > 26'h20000) return 26'h20000;
    return delta_i;
  endfunction

  task automatic model_step(input logic [31:0] s, output logic [31:0] expv);
    int ri;
    int hold_eff;
    logic signed [32:0] sm;
    ref_a[wr_m] = s;
    ref_b[(wr_m + 512) % 1024] = s;
    ri = int'(rd_m[25:16]);
    sm = $signed({ref_a[ri][31], ref_a[ri]}) + $signed({ref_b[ri][31], ref_b[ri]});
    expv = sm[32:1];
    rd_m = rd_m + delta_ref();
    wr_m = (wr_m + 1) % 1024;
    if (mod_en_i) begin
      hold_eff = (hold_i == 0) ? 1 : int'(hold_i);
      if (cnt_m + 1 >= hold_eff) begin
        cnt_m = 0;
        idx_m = (idx_m + 1) % 512;
      end else cnt_m++;
    end
  endtask

  task automatic set_mode(input logic m, input logic [15:0] h);
    @(negedge clk_i);
    mod_en_i = m;
    hold_i = h;
    if (!m) begin
      idx_m = 0;
      cnt_m = 0;
    end
    @(negedge clk_i);
  endtask

  task automatic send(input logic [31:0] s, input string tag);
    logic [31:0] expv;
    logic        lat_ok;
    @(negedge clk_i);
    valid_i = 1'b1;
    data_i = s;
    @(negedge clk_i);
    valid_i = 1'b0;
    model_step(s, expv);
    lat_ok = (valid_o == 1'b0);
    @(negedge clk_i); lat_ok &= (valid_o == 1'b0);
    @(negedge clk_i); lat_ok &= (valid_o == 1'b0);
    @(negedge clk_i); lat_ok &= (valid_o == 1'b1);
    if (n_samp % 64 == 0) chk("R2 latency", {31'd0, lat_ok}, 32'd1);
    if (n_samp >= 1024) chk(tag, data_o, expv);
    n_samp++;
  endtask

  task automatic send_double(input logic [31:0] s1, input logic [31:0] s2);
    logic [31:0] expv;
    logic [31:0] got;
    int pulses;
    @(negedge clk_i); valid_i = 1'b1; data_i = s1;
    @(negedge clk_i); data_i = s2;
    @(negedge clk_i); valid_i = 1'b0;
    model_step(s1, expv);
    n_samp++;
    pulses = 0;
    got = '0;
    for (int i = 0; i < 7; i++) begin
      if (valid_o) begin pulses++; got = data_o; end
      @(negedge clk_i);
    end
    chk("R2 single pulse", pulses, 1);
    chk("R2 first sample kept", got, expv);
  endtask

  initial begin
    #2ms;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R1 valid_o in reset", {31'd0, valid_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 valid_o after reset", {31'd0, valid_o}, 32'd0);
    chk("R1 data_o after reset", data_o, 32'd0);

    // R3/R4: unity ratio, read slot equals buffer A write slot
    for (int i = 0; i < 1100; i++) send($urandom, "R3 unity write/read");
    for (int i = 0; i < 40; i++) send($urandom, "R4 same-slot read");

    // R6: random legal ratios
    for (int b = 0; b < 8; b++) begin
      @(negedge clk_i);
      delta_i = 26'(32'h8000 + $urandom_range(0, 32'h18000));
      for (int i = 0; i < 40; i++) send($urandom, "R6 ratio step");
    end

    // R4: half ratio repeats slots
    @(negedge clk_i); delta_i = 26'h08000;
    for (int i = 0; i < 60; i++) send($urandom, "R4 half ratio");

    // R5: extreme values
    send(32'h8000_0000, "R5 min avg");
    send(32'h7FFF_FFFF, "R5 max avg");
    for (int i = 0; i < 20; i++) send((i % 2) ? 32'h8000_0000 : 32'hFFFF_FFFF, "R5 extremes");

    // R7: clamping
    @(negedge clk_i); delta_i = 26'h00100;
    for (int i = 0; i < 80; i++) send($urandom, "R7 clamp low");
    @(negedge clk_i); delta_i = 26'h3F_0000;
    for (int i = 0; i < 80; i++) send($urandom, "R7 clamp high");

    // R8: table walk with step every sample, crosses index wrap
    set_mode(1'b1, 16'd0);
    for (int i = 0; i < 600; i++) send($urandom, "R8 triangle");

    // R9: leave mode clears index, then hold counts
    set_mode(1'b0, 16'd0);
    @(negedge clk_i); delta_i = 26'h10000;
    send($urandom, "R9 manual between");
    set_mode(1'b1, 16'd3);
    for (int i = 0; i < 200; i++) send($urandom, "R9 hold 3");
    set_mode(1'b1, 16'd7);
    for (int i = 0; i < 120; i++) send($urandom, "R9 hold 7");

    // R2: second pulse during busy ignored
    set_mode(1'b0, 16'd0);
    send_double(32'h1234_5678, 32'hDEAD_BEEF);
    for (int i = 0; i < 30; i++) send($urandom, "R2 after double");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule